// File: doc/BRIEF.md
# Shadow-Loaded Pulse-Width Modulator

This block produces one pulse-width modulated output. A small 16-bit register port programs it: a write strobe, a two-bit word address, write data, and read data that comes back one clock after the address is presented. Software writes a duty ratio and a clock divider into staging registers. These values do not affect the waveform until a load command copies both of them into the active generator in a single step. A separate enable bit starts and stops the output.

Each period has 256 phase steps. The phase counter advances by one step each time the prescaler reaches the active divider value, so one period lasts 256 × (divider + 1) clocks. The output is high while the phase is below the active ratio. The ratio field is 9 bits wide, so any ratio of 256 or more keeps the output high for the full period. When the generator is running, a load waits until the end of the current period. No period is ever cut short.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After a synchronous reset, `pwm_out` is 0 and reads of addresses 0, 1 and 2 all return 0.
- R2: Register map by word address. Address 0 holds the ratio in bits 8:0, and bits 15:9 read as 0. Address 1 holds the 16-bit divider. Address 2 is control: bit 0 is enable and bit 1 is load. `rdata` shows the register selected by `addr` one clock after `addr` is presented.
- R3: Writes to the ratio or divider change only the staged copy. The waveform keeps its old ratio and period until a load is issued.
- R4: The load bit clears itself and always reads as 0. A load takes effect at once while enable is 0. While enable is 1, it takes effect only at the end of the current period (last phase step and prescaler at the divider), so the running period finishes with the old values.
- R5: While enabled, the distance between consecutive rising edges of `pwm_out` is 256 × (divider + 1) clocks.
- R6: For an active ratio r below 256, `pwm_out` is high for exactly r × (divider + 1) clocks of every period.
- R7: An active ratio of 0 keeps `pwm_out` low. An active ratio from 256 to 511 keeps `pwm_out` high for as long as the block is enabled.
- R8: While enable is 0, `pwm_out` is low and the prescaler and phase are held at zero. A fresh enable starts a period at phase 0, and the output rises on the second clock after the enabling write.
- R9: Address 3 reads as 0. Writes to address 3 change no register.
- R10: The shutdown sequence leaves `pwm_out` low, reads control as 0, and leaves the active ratio at 0. The sequence is: write ratio 0, write control with load set, write control 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that the prescaler divides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| pwm_out | output | 1 | Modulated output, registered |

## Verification
The assertions check every cycle that the active ratio and divider change only while the generator is stopped or at a period end. They also check that the prescaler never passes the divider, that the phase moves only on a prescaler wrap and returns to 0 after a period end, and that the output follows the zero, full and disabled cases. Other properties can only be shown by the bench scenarios: the exact high-time count and period length across a sweep of ratios and dividers, the delay of a load issued in the middle of a period, the restart phase after enable, and the shutdown sequence.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned ADR_W   = 2;
  localparam int unsigned PHASE_W = 8;
  localparam int unsigned RATIO_W = PHASE_W + 1;
  localparam int unsigned DIV_W   = 16;

  typedef enum logic [ADR_W-1:0] {
    SEL_RATIO = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_LOAD_BIT = 1;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned AW = ADR_W,
  parameter int unsigned RW = RATIO_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          period_end,
  output logic          run_en,
  output logic [RW-1:0] act_ratio,
  output logic [DW-1:0] act_div
);
  localparam int unsigned RPAD = W - RW;
  localparam int unsigned DPAD = W - DW;

  logic [RW-1:0] stg_ratio;
  logic [DW-1:0] stg_div;
  logic          load_pend;
  logic          apply_now;

  assign apply_now = load_pend && (!run_en || period_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_ratio <= '0;
      stg_div   <= '0;
      run_en    <= 1'b0;
      load_pend <= 1'b0;
      act_ratio <= '0;
      act_div   <= '0;
    end else begin
      if (apply_now) begin
        act_ratio <= stg_ratio;
        act_div   <= stg_div;
        load_pend <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          SEL_RATIO: stg_ratio <= wdata[RW-1:0];
          SEL_DIV:   stg_div   <= wdata[DW-1:0];
          SEL_CTRL: begin
            run_en <= wdata[CTRL_EN_BIT];
            if (wdata[CTRL_LOAD_BIT]) load_pend <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        SEL_RATIO: rdata <= {{RPAD{1'b0}}, stg_ratio};
        SEL_DIV:   rdata <= {{DPAD{1'b0}}, stg_div};
        SEL_CTRL:  rdata <= {{(W-1){1'b0}}, run_en};
        default:   rdata <= '0;
      endcase
    end
  end

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_ratio) || !$stable(act_div)) |-> $past(!run_en || period_end)) else $error("load timing"); // R4

  AST_SPARE_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEL_SPARE) |=> ($stable(stg_ratio) && $stable(stg_div) && $stable(run_en))) else $error("spare write"); // R9

  AST_CTRL_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
    (addr == SEL_CTRL) |=> (rdata[W-1:1] == '0)) else $error("ctrl read"); // R4
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = en && (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt >= div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= div)) else $error("prescaler past divider"); // R5

  AST_PRESCALE_HELD: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0)) else $error("prescaler not held"); // R8
endmodule

// File: rtl/pwm_phase_out.sv
module pwm_phase_out
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [RW-1:0] ratio,
  output logic          period_end,
  output logic          pwm_out
);
  localparam logic [PW-1:0] LAST = {PW{1'b1}};

  logic [PW-1:0] phase;
  logic          above;

  assign period_end = tick && (phase == LAST);
  assign above      = ({1'b0, phase} < ratio);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= '0;
    end else if (tick) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= en && above;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(phase)) else $error("phase moved"); // R5

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (phase == '0)) else $error("phase wrap"); // R5

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_out && phase == '0)) else $error("disabled output"); // R8

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (ratio == '0) |=> !pwm_out) else $error("zero ratio high"); // R7

  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (en && ratio[RW-1]) |=> pwm_out) else $error("full ratio low"); // R7
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned AW = ADR_W,
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          pwm_out
);
  localparam int unsigned RW = PW + 1;

  logic          run_en;
  logic [RW-1:0] act_ratio;
  logic [DW-1:0] act_div;
  logic          tick;
  logic          period_end;

  pwm_regfile #(.W(W), .AW(AW), .RW(RW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .period_end (period_end),
    .run_en     (run_en),
    .act_ratio  (act_ratio),
    .act_div    (act_div)
  );

  pwm_prescaler #(.DW(DW)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (run_en),
    .div  (act_div),
    .tick (tick)
  );

  pwm_phase_out #(.PW(PW), .RW(RW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .en         (run_en),
    .tick       (tick),
    .ratio      (act_ratio),
    .period_end (period_end),
    .pwm_out    (pwm_out)
  );
endmodule

// File: tb/sim_pwm_shadow_gen.sv
module sim_pwm_shadow_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        pwm_out;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwm_shadow_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0; wdata = 16'd0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = int'(rdata);
    addr = 2'd0;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
  endtask

  task automatic wait_rise(output int cycles);
    cycles = 0;
    while (pwm_out !== 1'b0 && cycles < 5000) begin @(negedge clk); cycles++; end
    while (pwm_out !== 1'b1 && cycles < 5000) begin @(negedge clk); cycles++; end
  endtask

  task automatic setup(input int r, input int d);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'(r));
    wr(2'd1, 16'(d));
    wr(2'd2, 16'h0002);
    wr(2'd2, 16'h0001);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, c, per;
    int ratios[9] = '{0, 1, 2, 127, 128, 255, 256, 300, 511};
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1", "pwm_out after reset", int'(pwm_out), 0);
    rd(2'd0, v); check("R1", "ratio read", v, 0);
    rd(2'd1, v); check("R1", "divider read", v, 0);
    rd(2'd2, v); check("R1", "control read", v, 0);

    // R2 register map and field widths
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R2", "ratio 9-bit field", v, 16'h01FF);
    wr(2'd1, 16'hA5C3); rd(2'd1, v); check("R2", "divider field", v, 16'hA5C3);
    wr(2'd2, 16'hFFFD); rd(2'd2, v); check("R2", "control read enable only", v, 1);
    wr(2'd2, 16'h0000);

    // R9 spare address
    wr(2'd0, 16'h0055); wr(2'd1, 16'h0007);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); check("R9", "spare read", v, 0);
    rd(2'd0, v); check("R9", "ratio after spare write", v, 16'h0055);
    rd(2'd1, v); check("R9", "divider after spare write", v, 7);
    rd(2'd2, v); check("R9", "control after spare write", v, 0);
    check("R9", "output after spare write", int'(pwm_out), 0);

    // R6 / R7 sweep of ratio x divider
    for (int d = 0; d < 3; d++) begin
      for (int k = 0; k < 9; k++) begin
        int r, exp_h;
        r = ratios[k];
        setup(r, d);
        repeat (8) @(negedge clk);
        count_high(256 * (d + 1), c);
        exp_h = ((r > 256) ? 256 : r) * (d + 1);
        if (r == 0 || r >= 256)
          check("R7", $sformatf("high count r=%0d d=%0d", r, d), c, exp_h);
        else
          check("R6", $sformatf("high count r=%0d d=%0d", r, d), c, exp_h);
      end
    end

    // R5 period length
    for (int d = 0; d < 4; d++) begin
      setup(100, d);
      wait_rise(per);
      wait_rise(per);
      check("R5", $sformatf("rise-to-rise d=%0d", d), per, 256 * (d + 1));
    end

    // R3 staging: new values written without load do not take effect
    setup(64, 0);
    repeat (5) @(negedge clk);
    wr(2'd0, 16'd200);
    wr(2'd1, 16'd2);
    count_high(256, c); check("R3", "high count w/o load", c, 64);
    wait_rise(per); wait_rise(per); check("R3", "period w/o load", per, 256);

    // R4 deferred load while running
    wr(2'd1, 16'd0);
    wr(2'd0, 16'd192);
    wait_rise(per);
    while (pwm_out === 1'b1) @(negedge clk);
    repeat (30) @(negedge clk);
    wr(2'd2, 16'h0003);
    rd(2'd2, v); check("R4", "load reads zero", v, 1);
    count_high(100, c); check("R4", "no early apply", c, 0);
    wait_rise(per);
    c = 0;
    while (pwm_out === 1'b1 && c < 1000) begin @(negedge clk); c++; end
    check("R4", "new ratio after boundary", c, 192);

    // R4 immediate load while disabled
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'd10);
    wr(2'd2, 16'h0002);
    wr(2'd2, 16'h0001);
    @(negedge clk);
    // R8 restart at phase 0: output high on the second clock after enable
    check("R8", "rise after enable", int'(pwm_out), 1);
    c = 0;
    while (pwm_out === 1'b1 && c < 1000) begin @(negedge clk); c++; end
    check("R4", "immediate load high run", c, 10);

    // R8 disabled holds low
    wr(2'd0, 16'd511); wr(2'd2, 16'h0002);
    wr(2'd2, 16'h0000);
    count_high(300, c); check("R8", "disabled output low", c, 0);

    // R10 shutdown sequence from a running full-high state
    setup(511, 1);
    repeat (4) @(negedge clk);
    check("R10", "running high before shutdown", int'(pwm_out), 1);
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h0003);
    wr(2'd2, 16'h0000);
    repeat (2) @(negedge clk);
    count_high(600, c); check("R10", "low after shutdown", c, 0);
    rd(2'd2, v); check("R10", "control after shutdown", v, 0);
    wr(2'd2, 16'h0001);
    count_high(600, c); check("R10", "active ratio zero on re-enable", c, 0);
    wr(2'd2, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule